// File: doc/BRIEF.md
# Sequential HI/LO Integer Multiplier

This block multiplies two 32-bit integers over a fixed number of clock cycles and returns the double-width product as a high word and a low word. A one-cycle start request loads both operands and a mode select. The block then runs one shift-and-add step per cycle, with a single adder/subtractor and a product register twice the operand width. The multiplier operand is loaded into the low half of that register. Each step shifts it out one bit at a time while the partial product moves in from the top.

In unsigned mode the step looks at one multiplier bit and either adds the multiplicand or adds nothing. In signed mode the step looks at the current multiplier bit together with the bit examined one step earlier (Booth recoding). From that pair it adds, subtracts or skips the multiplicand. The right shift fills with the true sign of the partial product in signed mode and with the adder carry in unsigned mode. The caller sees a busy level while the operation runs and a one-cycle done pulse at the end. The result words then stay fixed until the next accepted start.

Top module: `hilo_seq_mul`

## Requirements
- R1: While reset is low at a clock edge, the following edge leaves busy_o at 0, done_o at 0, and hi_o and lo_o at zero.
- R2: With signed_i = 0 at start, {hi_o, lo_o} equals the unsigned 64-bit product of mcand_i and mplier_i. hi_o carries bits 63..32 and lo_o carries bits 31..0.
- R3: With signed_i = 1 at start, {hi_o, lo_o} equals the two's-complement 64-bit product of the operands. This includes the case where the multiplicand is the most negative value.
- R4: Operands whose product needs more than 32 bits give the full 64-bit product in both modes, including all-ones unsigned operands and most-negative signed operands. The block has no overflow output.
- R5: A start sampled while busy_o is 0 raises busy_o after that edge. busy_o stays high for exactly 32 cycles. done_o rises on the same edge that clears busy_o.
- R6: done_o is high for exactly one cycle per accepted operation.
- R7: From the done cycle until the next accepted start, hi_o and lo_o do not change, even when the operand and mode inputs change.
- R8: A start request while busy_o is 1 is ignored. It does not restart the count or alter the result, even if it carries different operands and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |

## Verification
The hardest case to reach from the ports is a Booth subtraction that overflows the operand width. It occurs when the multiplicand is the most negative value and the first multiplier bit pair selects a subtract, so the partial product's sign is only correct if the extra adder bit is used. The stimulus drives that multiplicand against multipliers of 1, of itself and of the largest positive value. It also covers a start request that arrives in the middle of a run, carrying different operands and the opposite mode. That request is raised at a known step count, and the final product is compared against the first operands only.

// File: rtl/mul_seq_pkg.sv
// Shared types for the sequential multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package mul_seq_pkg;
    // Action taken on the upper product half in one step.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_op_e;
endpackage

// File: rtl/mul_step_decode.sv
// Chooses the step action from the current multiplier bit and the bit
// examined in the previous step.
// Assumes: prev_bit_i is 0 before the first step of an operation.
module mul_step_decode
    import mul_seq_pkg::*;
(
    input  logic     signed_mode_i,
    input  logic     cur_bit_i,
    input  logic     prev_bit_i,
    output step_op_e op_o
);
    // Unsigned: add on a 1. Signed: Booth pair 01 add, 10 subtract.
    always_comb begin
        if (!signed_mode_i) begin
            op_o = cur_bit_i ? STEP_ADD : STEP_HOLD;
        end else begin
            case ({cur_bit_i, prev_bit_i})
                2'b01:   op_o = STEP_ADD;
                2'b10:   op_o = STEP_SUB;
                default: op_o = STEP_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/mul_addsub.sv
// Adder/subtractor one bit wider than the operands. In signed mode both
// inputs are sign-extended, so the top bit is the true sign of the result.
// In unsigned mode they are zero-extended, so the top bit is the carry out.
// Assumes: a HOLD step passes the extended accumulator through unchanged.
module mul_addsub
    import mul_seq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             signed_mode_i,
    input  step_op_e         op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH:0]   res_o
);
    logic [WIDTH:0] acc_x;
    logic [WIDTH:0] mcand_x;

    // Extend both operands by one bit according to the mode.
    always_comb begin
        acc_x   = {signed_mode_i & acc_i[WIDTH-1],   acc_i};
        mcand_x = {signed_mode_i & mcand_i[WIDTH-1], mcand_i};
    end

    // Apply the selected action.
    always_comb begin
        case (op_i)
            STEP_ADD: res_o = acc_x + mcand_x;
            STEP_SUB: res_o = acc_x - mcand_x;
            default:  res_o = acc_x;
        endcase
    end
endmodule

// File: rtl/mul_step_ctrl.sv
// Sequencer: accepts a start when idle, counts WIDTH steps, then pulses
// done for one cycle.
// Assumes: start_i is ignored while busy.
module mul_step_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic             last_step;

    // Decode load, step and final-step conditions.
    always_comb begin
        load_o    = start_i && !busy_q;
        step_o    = busy_q;
        last_step = busy_q && (cnt_q == CNT_W'(WIDTH - 1));
    end

    // Busy flag, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_step;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (last_step) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/hilo_seq_mul.sv
// Top level of the sequential multiplier. It holds the double-width
// product register with the multiplier in its low half, the latched
// multiplicand and mode, and the previous-bit flag used for Booth steps.
// Assumes: synchronous active-low reset; there is no overflow detection.
module hilo_seq_mul
    import mul_seq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod_q;
    logic [WIDTH-1:0] mcand_q;
    logic             mode_q;
    logic             prev_q;
    logic             load;
    logic             step;
    step_op_e         op;
    logic [WIDTH:0]   sum;

    mul_step_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_step_decode u_dec (
        .signed_mode_i (mode_q),
        .cur_bit_i     (prod_q[0]),
        .prev_bit_i    (prev_q),
        .op_o          (op)
    );

    mul_addsub #(.WIDTH(WIDTH)) u_add (
        .signed_mode_i (mode_q),
        .op_i          (op),
        .acc_i         (prod_q[PW-1:WIDTH]),
        .mcand_i       (mcand_q),
        .res_o         (sum)
    );

    // Load operands on start; otherwise add/subtract, then shift right one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            mode_q  <= 1'b0;
            prev_q  <= 1'b0;
        end else if (load) begin
            prod_q  <= {{WIDTH{1'b0}}, mplier_i};
            mcand_q <= mcand_i;
            mode_q  <= signed_i;
            prev_q  <= 1'b0;
        end else if (step) begin
            prod_q  <= {sum, prod_q[WIDTH-1:1]};
            prev_q  <= prod_q[0];
        end
    end

    assign hi_o = prod_q[PW-1:WIDTH];
    assign lo_o = prod_q[WIDTH-1:0];
endmodule

// File: rtl/hilo_seq_mul_chk.sv
// Property checker for hilo_seq_mul, attached with bind.
// Assumes: the same WIDTH as the bound instance.
module hilo_seq_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int RUN_W = $clog2(WIDTH + 1) + 1;

    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && hi_o == '0 && lo_o == '0));

    assert_start_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == RUN_W'(WIDTH)));

    assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && run_len < RUN_W'(WIDTH - 1)) |=> busy_o);
endmodule

bind hilo_seq_mul hilo_seq_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/hilo_seq_mul_test.sv
`timescale 1ns/1ps
// Directed bench for hilo_seq_mul: one task per scenario.
module hilo_seq_mul_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] hi_o;
    logic [W-1:0] lo_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hilo_seq_mul #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .signed_i (signed_i),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .hi_o     (hi_o),
        .lo_o     (lo_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [W-1:0] a,
                                          input logic [W-1:0] b, input bit sgn);
        longint sa;
        longint sb;
        logic [63:0] ua;
        logic [63:0] ub;
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        ua = {32'b0, a};
        ub = {32'b0, b};
        return ua * ub;
    endfunction

    // R1: reset state at the ports.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R1", "busy/done in reset",
              {62'b0, busy_o, done_o}, 64'd0);
        check({hi_o, lo_o} == 64'd0, "R1", "hi/lo in reset", {hi_o, lo_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One operation with timing checks (R5, R6); optional mid-run start (R8).
    task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit sgn, input string req, input bit poke);
        logic [63:0] exp;
        bit timing_ok;
        exp = model(a, b, sgn);
        start_i = 1'b1; signed_i = sgn; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R5", "busy after start",
              {62'b0, busy_o, done_o}, 64'd2);
        timing_ok = 1'b1;
        for (int i = 1; i < W; i++) begin
            if (poke && i == 10) begin
                start_i = 1'b1; signed_i = ~sgn; mcand_i = ~a; mplier_i = b ^ 32'h5A5A_0F0F;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            if (!busy_o || done_o) timing_ok = 1'b0;
        end
        start_i = 1'b0;
        check(timing_ok, "R5", "busy held 32 cycles without done", {63'b0, timing_ok}, 64'd1);
        @(negedge clk);
        check(done_o && !busy_o, "R5", "done when busy clears",
              {62'b0, busy_o, done_o}, 64'd1);
        check({hi_o, lo_o} == exp, poke ? "R8" : req, "product", {hi_o, lo_o}, exp);
    endtask

    // R6/R7: done drops and result holds while inputs wander without start.
    task automatic t_hold();
        logic [63:0] kept;
        bit stable_ok;
        kept = {hi_o, lo_o};
        stable_ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            mcand_i = 32'h1234_0000 + 32'(i); mplier_i = ~mplier_i; signed_i = ~signed_i;
            @(negedge clk);
            if (i == 0)
                check(!done_o, "R6", "done one cycle only", {63'b0, done_o}, 64'd0);
            if ({hi_o, lo_o} != kept) stable_ok = 1'b0;
        end
        check(stable_ok, "R7", "hi/lo held after done", {hi_o, lo_o}, kept);
    endtask

    initial begin
        t_reset();
        t_mul(32'd3, 32'd5, 1'b0, "R2", 1'b0);
        t_hold();
        t_mul(32'hDEAD_BEEF, 32'h0001_0003, 1'b0, "R2", 1'b0);
        t_mul(32'd0, 32'hFFFF_FFFF, 1'b0, "R2", 1'b0);
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4", 1'b0);
        t_mul(32'h8000_0000, 32'd2, 1'b0, "R4", 1'b0);
        t_mul(32'hFFFF_FFFF, 32'd2, 1'b0, "R2", 1'b0);
        t_mul(32'hFFFF_FFFF, 32'd2, 1'b1, "R3", 1'b0);
        t_mul(32'hFFFF_FFF9, 32'd3, 1'b1, "R3", 1'b0);
        t_mul(32'd12345, 32'hFFFF_FD5A, 1'b1, "R3", 1'b0);
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3", 1'b0);
        t_mul(32'h8000_0000, 32'd1, 1'b1, "R3", 1'b0);
        t_mul(32'h8000_0000, 32'h8000_0000, 1'b1, "R4", 1'b0);
        t_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R4", 1'b0);
        t_mul(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R4", 1'b0);
        t_hold();
        t_mul(32'h0000_BEEF, 32'h0000_1235, 1'b0, "R8", 1'b1);
        t_mul(32'hFFFF_FF00, 32'h0000_0077, 1'b1, "R8", 1'b1);
        t_hold();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule